// File: doc/BRIEF.md
# Smart Card Character Shift Engine

This block moves characters between an 8-bit parallel side and the one-bit serial line of a smart card link. On the transmit side a holding register takes a character from the processor. The character is then sent as a start bit, eight data bits, an even parity bit and a high stop slot. On the receive side the engine waits for a low start bit, gathers eight data bits and a parity bit, and checks the parity. It then copies the character into a receive holding register and flags it.

Two static controls cover both card coding conventions: one picks which end of the character goes out first, the other complements every data and parity bit on the line. The transmit shifter rotates its contents instead of discarding them. After a frame the character is back in its original place, so a resend request can repeat it without a new write. All movement is paced by a one-cycle bit strobe, which an external timing unit supplies. The shifter changes state only on strobe cycles.

Top module: `sc_char_shifter`

## Requirements
- R1: After reset, ser_out is 1, tx_busy is 0, and rx_data, rx_full, rx_parity_err and rx_overrun are all 0.
- R2: ser_out and all receive state change only at a clock edge where bit_en is high; on other cycles ser_out holds its value.
- R3: When a character is waiting and the transmitter is idle, the next strobe drives a 0 start bit and raises tx_busy. Strobes 2 to 9 drive the data bits and strobe 10 drives the parity bit. Strobe 11 drives 1 and lowers tx_busy. A following character starts at the strobe after that.
- R4: With msb_first 0, data bit 0 goes first and bit 7 last; with msb_first 1, bit 7 goes first and bit 0 last. The receiver places bits using the same rule.
- R5: With invert 1, every data bit and the parity bit appear complemented on ser_out; the start bit (0) and the idle/stop level (1) are never complemented.
- R6: The parity bit before inversion is the XOR of the 8 logical data bits (even parity).
- R7: A tx_resend pulse while no new character is pending sends the last transmitted character again, unchanged.
- R8: A tx_wr during a frame does not disturb that frame; the new character is sent in the next frame.
- R9: A strobe with ser_in 0 while the receiver is idle starts a character; a strobe with ser_in 1 while idle does nothing. The 9 strobes after the start carry the data bits and then the parity bit. After the parity strobe's edge, rx_data holds the character and rx_full is 1.
- R10: Each received logical data bit equals ser_in XOR invert.
- R11: rx_parity_err is set with a stored character whose received logical parity differs from the XOR of its data bits, and is cleared with a stored character whose parity matches.
- R12: An rx_read pulse on a cycle without a store clears rx_full and rx_overrun at the next edge.
- R13: If a character is stored while rx_full is 1 and rx_read is 0, rx_overrun becomes 1 and rx_data takes the new character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | One-cycle bit strobe |
| msb_first | input | 1 | 1: bit 7 first on the line, 0: bit 0 first |
| invert | input | 1 | 1: complement data and parity on the line |
| tx_wr | input | 1 | Write tx_data into the transmit holding register |
| tx_data | input | 8 | Character to send |
| tx_resend | input | 1 | Request to repeat the last sent character |
| tx_busy | output | 1 | A frame is in progress |
| ser_out | output | 1 | Serial line output |
| ser_in | input | 1 | Serial line input, already synchronised |
| rx_read | input | 1 | Acknowledge the received character |
| rx_data | output | 8 | Last received character |
| rx_full | output | 1 | A received character is waiting |
| rx_parity_err | output | 1 | Parity of the stored character was wrong |
| rx_overrun | output | 1 | A character was stored over an unread one |

## Verification
Every output is a register, so a result is due at the clock edge where its strobe or pulse is high. The bench raises bit_en on a falling edge and reads the line, busy and receive flags on the next falling edge, half a cycle after the edge that updates them. Between strobes it inserts random idle cycles and checks that ser_out does not move, so a change outside a strobe would be caught at once. Receive flags are checked after each of the first nine strobes of a character to confirm that they do not change early, and after the parity strobe to confirm the stored result.

// File: rtl/sc_shift_pkg.sv
package sc_shift_pkg;
  // Line-level constants shared by both shifters.
  localparam logic LINE_IDLE  = 1'b1;
  localparam logic LINE_START = 1'b0;

  // Coding convention seen by the shifters.
  typedef struct packed {
    logic msb_first;
    logic invert;
  } conv_t;
endpackage

// File: rtl/sc_tx_shifter.sv
module sc_tx_shifter
  import sc_shift_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  conv_t             conv,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              resend,
  output logic              busy,
  output logic              line
);
  localparam int unsigned CW = $clog2(DATA_W + 3);
  localparam logic [CW-1:0] LAST_DATA = CW'(DATA_W);
  localparam logic [CW-1:0] PAR_SLOT  = CW'(DATA_W + 1);

  logic [DATA_W-1:0] hold_q, rot_q;
  logic              pend_q, again_q;
  logic [CW-1:0]     slot_q;
  logic              head_bit;
  logic [DATA_W-1:0] rot_next;

  // The rotation keeps every bit, so after DATA_W steps the character is restored.
  always_comb begin
    if (conv.msb_first) begin
      head_bit = rot_q[DATA_W-1];
      rot_next = {rot_q[DATA_W-2:0], rot_q[DATA_W-1]};
    end else begin
      head_bit = rot_q[0];
      rot_next = {rot_q[0], rot_q[DATA_W-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= '0;
      rot_q   <= '0;
      pend_q  <= 1'b0;
      again_q <= 1'b0;
      slot_q  <= '0;
      busy    <= 1'b0;
      line    <= LINE_IDLE;
    end else begin
      if (bit_en) begin
        if (!busy) begin
          if (pend_q || again_q) begin
            if (pend_q) rot_q <= hold_q;
            pend_q  <= 1'b0;
            again_q <= 1'b0;
            busy    <= 1'b1;
            slot_q  <= CW'(1);
            line    <= LINE_START;
          end
        end else if (slot_q <= LAST_DATA) begin
          line   <= head_bit ^ conv.invert;
          rot_q  <= rot_next;
          slot_q <= slot_q + CW'(1);
        end else if (slot_q == PAR_SLOT) begin
          line   <= (^rot_q) ^ conv.invert;
          slot_q <= slot_q + CW'(1);
        end else begin
          line   <= LINE_IDLE;
          busy   <= 1'b0;
          slot_q <= '0;
        end
      end
      // Requests arriving in a start cycle survive the clear above.
      if (wr) begin
        hold_q <= wdata;
        pend_q <= 1'b1;
      end
      if (resend) again_q <= 1'b1;
    end
  end
endmodule

// File: rtl/sc_rx_shifter.sv
module sc_rx_shifter
  import sc_shift_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  conv_t             conv,
  input  logic              line,
  input  logic              rd,
  output logic [DATA_W-1:0] data,
  output logic              full,
  output logic              par_err,
  output logic              overrun
);
  localparam int unsigned CW = $clog2(DATA_W + 2);
  localparam logic [CW-1:0] LAST_DATA = CW'(DATA_W);

  logic [DATA_W-1:0] sh_q;
  logic [CW-1:0]     slot_q;
  logic              active_q;
  logic              bit_log;
  logic              store;

  assign bit_log = line ^ conv.invert;
  assign store   = bit_en && active_q && (slot_q > LAST_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q     <= '0;
      slot_q   <= '0;
      active_q <= 1'b0;
      data     <= '0;
      full     <= 1'b0;
      par_err  <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      if (bit_en) begin
        if (!active_q) begin
          if (line == LINE_START) begin
            active_q <= 1'b1;
            slot_q   <= CW'(1);
          end
        end else if (slot_q <= LAST_DATA) begin
          if (conv.msb_first) sh_q <= {sh_q[DATA_W-2:0], bit_log};
          else                sh_q <= {bit_log, sh_q[DATA_W-1:1]};
          slot_q <= slot_q + CW'(1);
        end else begin
          active_q <= 1'b0;
          slot_q   <= '0;
          data     <= sh_q;
          par_err  <= bit_log ^ (^sh_q);
        end
      end
      if (store)   full <= 1'b1;
      else if (rd) full <= 1'b0;
      if (store && full && !rd) overrun <= 1'b1;
      else if (rd)              overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/sc_char_shifter.sv
module sc_char_shifter
  import sc_shift_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              msb_first,
  input  logic              invert,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_resend,
  output logic              tx_busy,
  output logic              ser_out,
  input  logic              ser_in,
  input  logic              rx_read,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              rx_parity_err,
  output logic              rx_overrun
);
  conv_t conv;
  assign conv = '{msb_first: msb_first, invert: invert};

  sc_tx_shifter #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst(rst), .bit_en(bit_en), .conv(conv),
    .wr(tx_wr), .wdata(tx_data), .resend(tx_resend),
    .busy(tx_busy), .line(ser_out)
  );

  sc_rx_shifter #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst(rst), .bit_en(bit_en), .conv(conv),
    .line(ser_in), .rd(rx_read), .data(rx_data), .full(rx_full),
    .par_err(rx_parity_err), .overrun(rx_overrun)
  );
endmodule

// File: rtl/sc_char_shifter_chk.sv
module sc_char_shifter_chk (
  input logic clk,
  input logic rst,
  input logic bit_en,
  input logic tx_busy,
  input logic ser_out,
  input logic rx_read,
  input logic rx_full,
  input logic rx_overrun
);
  a_r2_line_holds: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(ser_out));

  a_r3_idle_high: assert property (@(posedge clk) disable iff (rst)
    !tx_busy |-> ser_out);

  a_r3_start_low: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_busy) |-> !ser_out);

  a_r9_full_on_strobe: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_full) |-> $past(bit_en));

  a_r12_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rx_read && !bit_en) |=> (!rx_full && !rx_overrun));

  a_r13_overrun_needs_full: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_overrun) |-> $past(rx_full));
endmodule

bind sc_char_shifter sc_char_shifter_chk u_chk (
  .clk(clk), .rst(rst), .bit_en(bit_en), .tx_busy(tx_busy),
  .ser_out(ser_out), .rx_read(rx_read), .rx_full(rx_full),
  .rx_overrun(rx_overrun)
);

// File: tb/sim_sc_char_shifter.sv
module sim_sc_char_shifter;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 1'b0, msb_first = 1'b0, invert = 1'b0;
  logic tx_wr = 1'b0, tx_resend = 1'b0, ser_in = 1'b1, rx_read = 1'b0;
  logic [7:0] tx_data = '0;
  logic tx_busy, ser_out, rx_full, rx_parity_err, rx_overrun;
  logic [7:0] rx_data;

  int nchk = 0, nerr = 0;
  logic finished = 1'b0;
  logic exp_full = 1'b0, exp_ovr = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_char_shifter #(.DATA_W(8)) u0 (
    .clk(clk), .rst(rst), .bit_en(bit_en), .msb_first(msb_first),
    .invert(invert), .tx_wr(tx_wr), .tx_data(tx_data),
    .tx_resend(tx_resend), .tx_busy(tx_busy), .ser_out(ser_out),
    .ser_in(ser_in), .rx_read(rx_read), .rx_data(rx_data),
    .rx_full(rx_full), .rx_parity_err(rx_parity_err),
    .rx_overrun(rx_overrun)
  );

  // Line level at strobe k (1..11) of a frame for character c.
  function automatic logic line_bit(input logic [7:0] c, input int k,
                                    input logic msb, input logic inv);
    if (k == 1) return 1'b0;
    if (k <= 9) return c[msb ? 9 - k : k - 2] ^ inv;
    if (k == 10) return (^c) ^ inv;
    return 1'b1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Random gap with R2 stability check, then one strobe cycle.
  task automatic strobe(input logic din);
    logic prev;
    prev = ser_out;
    repeat ($urandom_range(0, 2)) begin
      @(negedge clk);
      chk("R2 line stable between strobes", 32'(ser_out), 32'(prev));
    end
    ser_in = din;
    bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
    ser_in = 1'b1;
  endtask

  task automatic set_conv(input logic msb, input logic inv);
    msb_first = msb;
    invert = inv;
  endtask

  task automatic write_char(input logic [7:0] c);
    tx_data = c;
    tx_wr = 1'b1;
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  // Send one frame (loaded beforehand) and check all 11 strobes.
  task automatic tx_check(input logic [7:0] c, input string req);
    for (int k = 1; k <= 11; k++) begin
      strobe(1'b1);
      chk($sformatf("%s R3/R4/R5/R6 line strobe %0d", req, k),
          32'(ser_out), 32'(line_bit(c, k, msb_first, invert)));
      chk($sformatf("%s R3 busy strobe %0d", req, k),
          32'(tx_busy), 32'(k <= 10));
    end
  endtask

  // Drive one received character; check flags before and after storage.
  task automatic rx_char(input logic [7:0] c, input logic bad_par);
    for (int k = 1; k <= 10; k++) begin
      strobe(line_bit(c, k, msb_first, invert) ^ (bad_par && k == 10));
      if (k < 10) chk("R9 rx_full not early", 32'(rx_full), 32'(exp_full));
    end
    exp_ovr = exp_ovr | exp_full;
    exp_full = 1'b1;
    chk("R9/R4/R10 rx_data", 32'(rx_data), 32'(c));
    chk("R9 rx_full set", 32'(rx_full), 32'(1));
    chk("R11 rx_parity_err", 32'(rx_parity_err), 32'(bad_par));
    chk("R13 rx_overrun", 32'(rx_overrun), 32'(exp_ovr));
  endtask

  task automatic rx_ack();
    rx_read = 1'b1;
    @(negedge clk);
    rx_read = 1'b0;
    exp_full = 1'b0;
    exp_ovr = 1'b0;
    chk("R12 rx_full cleared", 32'(rx_full), 32'(0));
    chk("R12 rx_overrun cleared", 32'(rx_overrun), 32'(0));
  endtask

  initial begin
    void'($urandom(32'h5eed_0816));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 ser_out", 32'(ser_out), 32'(1));
    chk("R1 tx_busy", 32'(tx_busy), 32'(0));
    chk("R1 rx_data", 32'(rx_data), 32'(0));
    chk("R1 rx_full", 32'(rx_full), 32'(0));
    chk("R1 rx_parity_err", 32'(rx_parity_err), 32'(0));
    chk("R1 rx_overrun", 32'(rx_overrun), 32'(0));

    // R9: idle strobes with a high line start nothing
    repeat (12) strobe(1'b1);
    chk("R9 idle high ignored", 32'(rx_full), 32'(0));
    chk("R3 no frame without request", 32'(tx_busy), 32'(0));

    // Directed: all four conventions on an asymmetric character
    for (int m = 0; m < 4; m++) begin
      set_conv(m[1], m[0]);
      write_char(8'h3B);
      tx_check(8'h3B, "R4 direction/invert");
    end

    // R7: repeat without reload
    set_conv(1'b1, 1'b1);
    write_char(8'hA5);
    tx_check(8'hA5, "R7 first");
    tx_resend = 1'b1;
    @(negedge clk);
    tx_resend = 1'b0;
    tx_check(8'hA5, "R7 repeat");

    // R8: write during a frame waits for the next frame
    set_conv(1'b0, 1'b0);
    write_char(8'h81);
    for (int k = 1; k <= 11; k++) begin
      strobe(1'b1);
      if (k == 4) write_char(8'h7E);
      chk($sformatf("R8 first frame strobe %0d", k),
          32'(ser_out), 32'(line_bit(8'h81, k, 1'b0, 1'b0)));
    end
    tx_check(8'h7E, "R8 second");

    // Receive: directed conventions, parity error, overrun, acknowledge
    set_conv(1'b0, 1'b0);
    rx_char(8'hC3, 1'b0);
    rx_ack();
    set_conv(1'b1, 1'b1);
    rx_char(8'h3B, 1'b1);
    rx_char(8'h5A, 1'b0);
    rx_ack();

    // Random mix
    for (int i = 0; i < 40; i++) begin
      logic [7:0] c;
      c = 8'($urandom());
      set_conv(1'($urandom()), 1'($urandom()));
      if ($urandom_range(0, 1) == 1) begin
        if ($urandom_range(0, 2) == 0) begin
          tx_resend = 1'b1;
          @(negedge clk);
          tx_resend = 1'b0;
          tx_check(last_tx, "R7 random repeat");
        end else begin
          write_char(c);
          last_tx = c;
          tx_check(c, "R3 random");
        end
      end else begin
        rx_char(c, 1'($urandom_range(0, 3) == 0));
        if ($urandom_range(0, 2) != 0) rx_ack();
      end
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  logic [7:0] last_tx = 8'h7E;

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule